// File: doc/BRIEF.md
# Derangement Word Stream Cipher

This block encrypts or decrypts a byte stream in 32-bit words. Bytes arrive over a valid/ready input port and are gathered into a word. For every word an on-chip generator produces a fresh derangement of the 32 bit positions, meaning a bit order in which no bit keeps its own place. The word's bits are moved through that derangement and combined by XOR with 32 bits drawn from a linear feedback shift register key stream. The result leaves as four bytes over a valid/ready output port.

The derangement generator keeps one up/down counter per network column. The counters drive a cascade of transpositions that forms a permutation. On each step the counters move together, and the permutation is tested. Stepping repeats, one step per clock, until a derangement appears. The key stream is needed because moving bits around can never change a word of all zeros or all ones. Decoding uses the same key stream and the same derangement sequence from reset, and applies the inverse mapping, so a decoder started from reset recovers what an encoder started from reset produced. Output draining overlaps with collecting and processing the next word.

Top module: `derange_word_cipher`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is low and `in_ready` is high. After reset the key register holds the nonzero `SEED` and every column counter is 0.
- R2: The first input byte of a word becomes bits 7:0 of that word, and the fourth becomes bits 31:24. Output bytes leave in the same order: bits 7:0 first.
- R3: In encode mode (`decode` = 0), output bit k equals input bit perm[k] XOR key bit k, where perm[k] is the source position that the current derangement assigns to output position k.
- R4: For every word, perm[k] differs from k for all k.
- R5: Counter i (1..31) holds a value in 0..i. The permutation starts from identity, and for i = 1..31 in turn positions i and counter[i] are swapped. When a word is full the counters take one step. While the result is not a derangement they step once per cycle. A step moves counter i up (wrapping i to 0) when key register bit i is 1, and down (wrapping 0 to i) when it is 0.
- R6: The key register is a 32-bit Galois LFSR that shifts right with feedback mask 0x80200003 when the bit shifted out is 1. Key bit k of a word is bit 0 before shift k. The register advances 32 shifts once per word and never holds zero.
- R7: In decode mode, output bit perm[k] equals input bit k XOR key bit k. A decode run from reset therefore returns the plaintext of an encode run from reset.
- R8: A byte is accepted only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low while four bytes are held. While `out_valid` is high and `out_ready` is low, `out_byte` and `out_valid` hold.
- R9: A finished word is loaded into the output register in the same cycle in which the previous word's last byte is taken, so no idle cycle falls between the words. `in_ready` rises again only in the cycle of such a load. `decode` is sampled at the load.
- R10: A word of all zeros encodes to exactly its key bits, so it is nonzero. A word of all ones encodes to the complement of its key bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| decode | input | 1 | 0 = encode, 1 = decode |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte |
| out_byte | output | 8 | Output byte |

## Verification
The two functions that can fall in one cycle are the load of a finished word into the output register and the hand-off of the last byte of the previous word. The bench provokes this by holding `out_ready` low for six of every eight cycles. Meanwhile the next word is already collected and its derangement found, so the result waits on the draining register. It judges the overlap at the ports: a last byte taken with `out_valid` still high on the following cycle proves the merge, and the bytes around it must match the arithmetic model with none lost or repeated.

// File: rtl/derange_word_cipher.sv
module derange_word_cipher #(
  parameter int WORD = 32,
  parameter logic [WORD-1:0] SEED = 32'hC0DE5EED,
  parameter logic [WORD-1:0] POLY = 32'h80200003
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       decode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte
);
  localparam int W   = $clog2(WORD);
  localparam int BPW = WORD / 8;
  localparam int CW  = $clog2(BPW + 1);

  logic [WORD-1:0] in_buf, out_buf, lfsr, lfsr_nx, ks, res;
  logic [CW-1:0]   in_cnt, out_cnt;
  logic            srch, is_der, load, step, start;
  logic [W-1:0]    ctr  [1:WORD-1];
  logic [W-1:0]    perm [WORD];

  assign in_ready  = in_cnt != CW'(BPW);
  assign out_valid = out_cnt != '0;
  assign out_byte  = out_buf[7:0];
  assign start     = !in_ready && !srch;
  assign load      = srch && is_der &&
                     (out_cnt == '0 || (out_cnt == CW'(1) && out_ready));
  assign step      = start || (srch && !is_der);

  always_comb begin
    logic [WORD-1:0] s;
    s = lfsr;
    for (int k = 0; k < WORD; k++) begin
      ks[k] = s[0];
      s = (s >> 1) ^ (s[0] ? POLY : '0);
    end
    lfsr_nx = s;
  end

  always_comb begin
    logic [W-1:0] p [WORD];
    logic [W-1:0] t;
    for (int k = 0; k < WORD; k++) p[k] = W'(k);
    for (int i = 1; i < WORD; i++) begin
      t         = p[i];
      p[i]      = p[ctr[i]];
      p[ctr[i]] = t;
    end
    perm   = p;
    is_der = 1'b1;
    for (int k = 0; k < WORD; k++)
      if (p[k] == W'(k)) is_der = 1'b0;
  end

  always_comb begin
    logic [WORD-1:0] y;
    y   = in_buf ^ ks;
    res = '0;
    for (int k = 0; k < WORD; k++) begin
      if (decode) res[perm[k]] = y[k];
      else        res[k]       = in_buf[perm[k]] ^ ks[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i < WORD; i++) ctr[i] <= '0;
    end else if (step) begin
      for (int i = 1; i < WORD; i++) begin
        if (lfsr[i]) ctr[i] <= (ctr[i] == W'(i)) ? '0 : ctr[i] + 1'b1;
        else         ctr[i] <= (ctr[i] == '0) ? W'(i) : ctr[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_buf  <= '0;
      in_cnt  <= '0;
      out_buf <= '0;
      out_cnt <= '0;
      lfsr    <= SEED;
      srch    <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        in_buf <= {in_byte, in_buf[WORD-1:8]};
        in_cnt <= in_cnt + 1'b1;
      end
      if (start) srch <= 1'b1;
      if (load) begin
        out_buf <= res;
        out_cnt <= CW'(BPW);
        lfsr    <= lfsr_nx;
        in_cnt  <= '0;
        srch    <= 1'b0;
      end else if (out_valid && out_ready) begin
        out_buf <= out_buf >> 8;
        out_cnt <= out_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/derange_word_cipher_chk.sv
module derange_word_cipher_chk #(
  parameter int WORD = 32,
  parameter int W    = 5,
  parameter int BPW  = 4,
  parameter int CW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [7:0]      out_byte,
  input logic [WORD-1:0] lfsr,
  input logic [CW-1:0]   out_cnt,
  input logic [W-1:0]    ctr [1:WORD-1]
);
  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  p_key_per_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lfsr != $past(lfsr)) |-> (out_cnt == CW'(BPW)));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  p_ready_reopen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (out_cnt == CW'(BPW)));

  for (genvar i = 1; i < WORD; i++) begin : g_rng
    p_ctr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctr[i] <= W'(i));
  end
endmodule

bind derange_word_cipher derange_word_cipher_chk #(
  .WORD(WORD), .W(W), .BPW(BPW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .lfsr(lfsr),
  .out_cnt(out_cnt), .ctr(ctr)
);

// File: tb/derange_word_cipher_tb.sv
module derange_word_cipher_tb;
  localparam logic [31:0] SEED = 32'hC0DE5EED;
  localparam logic [31:0] POLY = 32'h80200003;
  localparam int NW = 40;

  logic clk = 1'b0, rst_n = 1'b0, decode = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [7:0] in_byte = '0, out_byte;

  derange_word_cipher u_dut (
    .clk(clk), .rst_n(rst_n), .decode(decode), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  always #4 clk = ~clk;

  int vecs = 0, fails = 0, cyc = 0, seam = 0;
  logic [31:0] src [NW], din [NW], got [NW], enc [NW], exp_w [NW], exk [NW];
  logic [31:0] m_lfsr;
  int m_ctr [32];
  int m_p [32];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] ex);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  task automatic m_step();
    for (int i = 1; i < 32; i++) begin
      if (m_lfsr[i]) m_ctr[i] = (m_ctr[i] == i) ? 0 : m_ctr[i] + 1;
      else           m_ctr[i] = (m_ctr[i] == 0) ? i : m_ctr[i] - 1;
    end
  endtask

  function automatic bit m_perm_der();
    int t;
    bit d = 1'b1;
    for (int k = 0; k < 32; k++) m_p[k] = k;
    for (int i = 1; i < 32; i++) begin
      t = m_p[i]; m_p[i] = m_p[m_ctr[i]]; m_p[m_ctr[i]] = t;
    end
    for (int k = 0; k < 32; k++) if (m_p[k] == k) d = 1'b0;
    return d;
  endfunction

  task automatic model_run(input int n, input bit dec);
    logic [31:0] s, ks, y, r;
    m_lfsr = SEED;
    for (int i = 0; i < 32; i++) m_ctr[i] = 0;
    for (int w = 0; w < n; w++) begin
      s = m_lfsr;
      for (int k = 0; k < 32; k++) begin
        ks[k] = s[0];
        s = (s >> 1) ^ (s[0] ? POLY : 32'h0);
      end
      m_step();
      while (!m_perm_der()) m_step();
      y = din[w] ^ ks;
      r = '0;
      for (int k = 0; k < 32; k++) begin
        if (dec) r[m_p[k]] = y[k];
        else     r[k] = din[w][m_p[k]] ^ ks[k];
      end
      exp_w[w] = r;
      exk[w]   = ks;
      m_lfsr   = s;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic feed(input int n);
    int b = 0;
    while (b < n * 4) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = din[b / 4][8 * (b % 4) +: 8];
      #1;
      if (in_ready) b++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input int n, input bit slow);
    int b = 0;
    bit pend = 1'b0;
    while (b < n * 4) begin
      @(negedge clk);
      out_ready = slow ? ((cyc % 8) >= 6) : 1'b1;
      #1;
      if (pend) begin
        if (out_valid) seam++;
        pend = 1'b0;
      end
      if (out_valid && out_ready) begin
        got[b / 4][8 * (b % 4) +: 8] = out_byte;
        if (b % 4 == 3) pend = 1'b1;
        b++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run(input int n, input bit dec, input bit slow);
    do_reset();
    decode = dec;
    fork
      feed(n);
      collect(n, slow);
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    bit one_bit;
    src[0] = 32'h0;
    src[1] = 32'hFFFFFFFF;
    for (int j = 0; j < 32; j++) src[2 + j] = 32'h1 << j;
    src[34] = 32'h04030201;
    src[35] = 32'hA5A50F0F;
    for (int j = 36; j < NW; j++) src[j] = j * 32'h9E3779B9;

    // R1: state during and right after reset
    do_reset();
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", {31'b0, out_valid}, 32'h0);
    chk(in_ready == 1'b1, "R1 in_ready", {31'b0, in_ready}, 32'h1);

    // encode sweep, sink always ready
    for (int w = 0; w < NW; w++) din[w] = src[w];
    model_run(NW, 1'b0);
    run(NW, 1'b0, 1'b0);
    for (int w = 0; w < NW; w++) begin
      enc[w] = got[w];
      chk(got[w] === exp_w[w], "R1 R2 R3 R5 R6 encode", got[w], exp_w[w]);
    end
    // R10: all-zero and all-one words
    chk(got[0] === exk[0] && got[0] != 32'h0, "R10 zero word", got[0], exk[0]);
    chk(got[1] === ~exk[1], "R10 ones word", got[1], ~exk[1]);
    // R4: a single set bit must land on a different position
    for (int j = 0; j < 32; j++) begin
      logic [31:0] d;
      d = got[2 + j] ^ exk[2 + j];
      one_bit = ($countones(d) == 1) && !d[j];
      chk(one_bit, "R4 derangement moves bit", d, 32'h1 << j);
    end

    // R8 R9: same encode under heavy back-pressure gives the same stream
    seam = 0;
    run(NW, 1'b0, 1'b1);
    for (int w = 0; w < NW; w++)
      chk(got[w] === enc[w], "R8 backpressure encode", got[w], enc[w]);
    chk(seam > 0, "R9 load with last byte", seam, 1);

    // R7: decode of the encoded stream returns the plaintext
    for (int w = 0; w < NW; w++) din[w] = enc[w];
    run(NW, 1'b1, 1'b1);
    for (int w = 0; w < NW; w++)
      chk(got[w] === src[w], "R7 round trip", got[w], src[w]);

    // R7: decode of raw words against the inverse-mapping model
    for (int w = 0; w < NW; w++) din[w] = src[w];
    model_run(NW, 1'b1);
    run(NW, 1'b1, 1'b0);
    for (int w = 0; w < NW; w++)
      chk(got[w] === exp_w[w], "R7 decode model", got[w], exp_w[w]);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule